// File: doc/BRIEF.md
# Power-Up Reset and Boot Sequencer

This block controls how a processor core comes out of master reset. An active-low reset pin enters through a two-flop synchroniser. While that reset is held, the block asserts the core reset and three initialisation strobes: clear the stack pointers to empty, mask every interrupt, and clear the mode/status register. A power-up flag, sampled during reset, marks the reset as cold. After a cold reset the core stays in reset for a fixed lock interval so the clock multiplier can settle. A warm reset skips that interval, because the clock never stopped.

When reset is released, the block checks two inputs. If a bus request is pending, it holds the core in reset until the request drops. It then reads the boot-mode strap. With the strap at 0, it raises a boot request and waits for the loader to report completion. With the strap at 1, it goes straight to the first fetch. In both cases the core starts with a one-cycle fetch strobe that carries program address zero.

Top module: `rstboot_seq`

## Requirements
- R1: After a cold reset (power-up flag high while reset is applied), with no bus request and the strap at 1, core reset stays high and the fetch strobe appears exactly 3 + LOCK_CYCLES clock edges after the reset pin rises. LOCK_CYCLES defaults to 2000.
- R2: After a warm reset (power-up flag low), with no bus request and the strap at 1, the fetch strobe appears on the third clock edge after the reset pin rises.
- R3: While the sequencer is in reset or in the lock wait, sp_clr_o, irq_mask_all_o, stat_clr_o and core_rst_o are all 1. Outside those phases the three initialisation outputs are 0.
- R4: The reset pin passes through a two-flop synchroniser. A fall seen at a clock edge shows on the outputs after the third edge, and not before.
- R5: If bus_req_i is high when the sequencer leaves reset or the lock wait, core reset stays high and neither the boot request nor the fetch strobe is raised. On the edge after bus_req_i goes low, the strap decides what comes next.
- R6: With the strap at 0, boot_req_o stays high from release until boot_done_i is seen high. The fetch strobe follows on the next edge, and boot_req_o drops on that same edge.
- R7: With the strap at 1, boot_req_o is never raised and the fetch comes on the edge after release.
- R8: fetch_stb_o is high for exactly one cycle. While it is high, fetch_addr_o is 0 and core_rst_o is 0. After the strobe the core stays out of reset.
- R9: A low on the reset pin returns the sequencer to reset from any phase, including the lock wait and the boot phase. A reset that interrupts a lock wait with the power-up flag low behaves as a warm reset.
- R10: boot_done_i has no effect outside the boot phase. When the core is running, it causes no strobe and no reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| ext_rst_n | input | 1 | Asynchronous active-low master reset pin |
| pwr_up_i | input | 1 | High when the current reset follows power-up (cold) |
| bus_req_i | input | 1 | External bus request; delays release while high |
| boot_strap_i | input | 1 | 0 = boot-load before first fetch, 1 = fetch directly |
| boot_done_i | input | 1 | Loader reports boot image loaded |
| core_rst_o | output | 1 | Holds the core in reset |
| sp_clr_o | output | 1 | Set all stack pointers to empty |
| irq_mask_all_o | output | 1 | Mask every interrupt |
| stat_clr_o | output | 1 | Clear the mode/status register |
| boot_req_o | output | 1 | Boot loader run request (level) |
| fetch_stb_o | output | 1 | One-cycle first-fetch strobe |
| fetch_addr_o | output | ADDR_W | Fetch address, zero during the strobe |

## Verification
The phase register shows up directly at the ports. A phase that is wrong after release gives the wrong edge count to the fetch strobe: 3 edges for warm, 3 + LOCK_CYCLES for cold, plus the hold and boot delays the bench adds. A stuck counter or a lost cold flag therefore shows as a miscompare on the first cycle where the strobe arrives early or late. A wrong hold or boot decision shows within one cycle as a boot request or strobe that is present when it should be absent, or the reverse. The bench compares every output on every cycle, so it catches such errors immediately, not only at the end of a sequence.

// File: rtl/rstboot_pkg.sv
package rstboot_pkg;

    typedef enum logic [2:0] {
        PH_RESET = 3'd0,
        PH_LOCK  = 3'd1,
        PH_HOLD  = 3'd2,
        PH_BOOT  = 3'd3,
        PH_FETCH = 3'd4,
        PH_RUN   = 3'd5
    } phase_e;

    typedef struct packed {
        logic sp_clr;
        logic irq_mask_all;
        logic stat_clr;
    } init_ctl_t;

    // Where to go once reset and the lock wait are over.
    function automatic phase_e release_target(input logic bus_req, input logic strap);
        if (bus_req)
            return PH_HOLD;
        else if (!strap)
            return PH_BOOT;
        else
            return PH_FETCH;
    endfunction

    function automatic logic holds_core(input phase_e p);
        return (p == PH_RESET) || (p == PH_LOCK) || (p == PH_HOLD) || (p == PH_BOOT);
    endfunction

    function automatic init_ctl_t init_for(input phase_e p);
        init_ctl_t c;
        logic on;
        on = (p == PH_RESET) || (p == PH_LOCK);
        c.sp_clr       = on;
        c.irq_mask_all = on;
        c.stat_clr     = on;
        return c;
    endfunction

endpackage

// File: rtl/rstboot_sync.sv
module rstboot_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic async_rst_n,
    output logic rst_sync
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) chain[0] <= ~async_rst_n;
            end else begin : g_next
                always_ff @(posedge clk) chain[g] <= chain[g-1];
            end
        end
    endgenerate

    assign rst_sync = chain[STAGES-1];
endmodule

// File: rtl/rstboot_lock_timer.sv
module rstboot_lock_timer #(
    parameter int LIMIT = 2000
) (
    input  logic clk,
    input  logic clr,
    input  logic run,
    output logic done
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (clr)
            cnt <= '0;
        else if (run && cnt != LAST)
            cnt <= cnt + 1'b1;
    end

    assign done = run && (cnt == LAST);
endmodule

// File: rtl/rstboot_fsm.sv
module rstboot_fsm
    import rstboot_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   pwr_up,
    input  logic   bus_req,
    input  logic   strap,
    input  logic   boot_done,
    input  logic   lock_done,
    output phase_e phase
);
    phase_e phase_nx;
    logic   cold_q;

    // Cold/warm is decided by the flag seen during the last reset cycle.
    always_ff @(posedge clk) begin
        if (rst)
            cold_q <= pwr_up;
    end

    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_RESET: phase_nx = cold_q ? PH_LOCK : release_target(bus_req, strap);
            PH_LOCK:  if (lock_done) phase_nx = release_target(bus_req, strap);
            PH_HOLD:  if (!bus_req) phase_nx = release_target(1'b0, strap);
            PH_BOOT:  if (boot_done) phase_nx = PH_FETCH;
            PH_FETCH: phase_nx = PH_RUN;
            PH_RUN:   phase_nx = PH_RUN;
            default:  phase_nx = PH_RESET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            phase <= PH_RESET;
        else
            phase <= phase_nx;
    end
endmodule

// File: rtl/rstboot_seq.sv
module rstboot_seq
    import rstboot_pkg::*;
#(
    parameter int LOCK_CYCLES = 2000,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 14,
    parameter int RESET_VEC   = 0
) (
    input  logic              clk,
    input  logic              ext_rst_n,
    input  logic              pwr_up_i,
    input  logic              bus_req_i,
    input  logic              boot_strap_i,
    input  logic              boot_done_i,
    output logic              core_rst_o,
    output logic              sp_clr_o,
    output logic              irq_mask_all_o,
    output logic              stat_clr_o,
    output logic              boot_req_o,
    output logic              fetch_stb_o,
    output logic [ADDR_W-1:0] fetch_addr_o
);
    localparam logic [ADDR_W-1:0] VEC = ADDR_W'(RESET_VEC);

    logic      rst_sync;
    logic      lock_done;
    phase_e    phase;
    init_ctl_t init_ctl;

    rstboot_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk),
        .async_rst_n (ext_rst_n),
        .rst_sync    (rst_sync)
    );

    rstboot_lock_timer #(.LIMIT(LOCK_CYCLES)) u_lock (
        .clk  (clk),
        .clr  (phase != PH_LOCK),
        .run  (phase == PH_LOCK),
        .done (lock_done)
    );

    rstboot_fsm u_fsm (
        .clk       (clk),
        .rst       (rst_sync),
        .pwr_up    (pwr_up_i),
        .bus_req   (bus_req_i),
        .strap     (boot_strap_i),
        .boot_done (boot_done_i),
        .lock_done (lock_done),
        .phase     (phase)
    );

    assign init_ctl       = init_for(phase);
    assign sp_clr_o       = init_ctl.sp_clr;
    assign irq_mask_all_o = init_ctl.irq_mask_all;
    assign stat_clr_o     = init_ctl.stat_clr;
    assign core_rst_o     = holds_core(phase);
    assign boot_req_o     = (phase == PH_BOOT);
    assign fetch_stb_o    = (phase == PH_FETCH);
    assign fetch_addr_o   = fetch_stb_o ? VEC : '0;
endmodule

// File: rtl/rstboot_checks.sv
module rstboot_checks (
    input logic clk,
    input logic rst,
    input logic boot_strap,
    input logic bus_req,
    input logic boot_done,
    input logic core_rst,
    input logic sp_clr,
    input logic boot_req,
    input logic fetch_stb
);
    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (rst)
        fetch_stb |=> !fetch_stb);

    assert_core_free_at_fetch_R8: assert property (@(posedge clk) disable iff (rst)
        fetch_stb |-> !core_rst);

    assert_init_in_reset_R3: assert property (@(posedge clk) disable iff (rst)
        sp_clr |-> (core_rst && !boot_req && !fetch_stb));

    assert_done_to_fetch_R6: assert property (@(posedge clk) disable iff (rst)
        (boot_req && boot_done) |=> (fetch_stb && !boot_req));

    assert_strap_skips_boot_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(boot_req) |-> !$past(boot_strap));

    assert_hold_blocks_R5: assert property (@(posedge clk) disable iff (rst)
        (core_rst && !sp_clr && !boot_req && bus_req) |=> (!fetch_stb && !boot_req));

    assert_reset_returns_R9: assert property (@(posedge clk)
        rst |=> (sp_clr && core_rst));

    assert_done_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (!boot_req && boot_done && !core_rst) |=> !fetch_stb);
endmodule

bind rstboot_seq rstboot_checks u_checks (
    .clk        (clk),
    .rst        (rst_sync),
    .boot_strap (boot_strap_i),
    .bus_req    (bus_req_i),
    .boot_done  (boot_done_i),
    .core_rst   (core_rst_o),
    .sp_clr     (sp_clr_o),
    .boot_req   (boot_req_o),
    .fetch_stb  (fetch_stb_o)
);

// File: tb/test_rstboot_seq.sv
module test_rstboot_seq;
    localparam int L      = 2000;
    localparam int AW     = 14;
    localparam int HOLD_N = 4;
    localparam int BOOT_N = 5;

    logic          clk = 1'b0;
    logic          ext_rst_n = 1'b0;
    logic          pwr_up = 1'b1;
    logic          bus_req = 1'b0;
    logic          strap = 1'b1;
    logic          boot_done = 1'b0;
    logic          core_rst, sp_clr, irq_mask, stat_clr, boot_req, fetch_stb;
    logic [AW-1:0] fetch_addr;

    int vectors = 0;
    int errs    = 0;

    always #2.5 clk = ~clk;

    rstboot_seq #(.LOCK_CYCLES(L), .ADDR_W(AW)) i_rstboot_seq (
        .clk            (clk),
        .ext_rst_n      (ext_rst_n),
        .pwr_up_i       (pwr_up),
        .bus_req_i      (bus_req),
        .boot_strap_i   (strap),
        .boot_done_i    (boot_done),
        .core_rst_o     (core_rst),
        .sp_clr_o       (sp_clr),
        .irq_mask_all_o (irq_mask),
        .stat_clr_o     (stat_clr),
        .boot_req_o     (boot_req),
        .fetch_stb_o    (fetch_stb),
        .fetch_addr_o   (fetch_addr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_init(input string tag, input logic exp);
        chk(tag, {31'd0, sp_clr}, {31'd0, exp});
        chk(tag, {31'd0, irq_mask}, {31'd0, exp});
        chk(tag, {31'd0, stat_clr}, {31'd0, exp});
    endtask

    // Full release sequence; every cycle is compared against values computed here.
    task automatic scenario(input logic cold, input logic st, input logic req);
        int lock_end, decided, strobe_n;
        @(negedge clk);
        pwr_up = cold; bus_req = req; strap = st; boot_done = 1'b0; ext_rst_n = 1'b0;
        repeat (5) @(negedge clk);
        chk("R3 core_rst in reset", {31'd0, core_rst}, 32'd1);
        chk_init("R3 init in reset", 1'b1);
        ext_rst_n = 1'b1;
        lock_end = 3 + (cold ? L : 0);
        decided  = lock_end + (req ? HOLD_N : 0);
        strobe_n = decided + (st ? 0 : BOOT_N);
        for (int n = 1; n <= strobe_n + 2; n++) begin
            @(negedge clk);
            chk(cold ? "R1 core_rst" : "R2 core_rst", {31'd0, core_rst}, {31'd0, n < strobe_n});
            chk(cold ? "R1 strobe" : "R2 strobe", {31'd0, fetch_stb}, {31'd0, n == strobe_n});
            chk_init("R3 init window", n < lock_end);
            if (req && n >= lock_end && n < decided)
                chk("R5 hold no boot", {31'd0, boot_req}, 32'd0);
            else if (st)
                chk("R7 no boot", {31'd0, boot_req}, 32'd0);
            else
                chk("R6 boot_req", {31'd0, boot_req}, {31'd0, (n >= decided) && (n < strobe_n)});
            if (n == strobe_n)
                chk("R8 fetch addr", {{(32-AW){1'b0}}, fetch_addr}, 32'd0);
            if (req && n == decided - 1) bus_req = 1'b0;
            if (!st && n == strobe_n - 1) boot_done = 1'b1;
        end
        boot_done = 1'b0;
        pwr_up = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk("R3 core_rst at start", {31'd0, core_rst}, 32'd1);
        chk_init("R3 init at start", 1'b1);
        chk("R8 no strobe at start", {31'd0, fetch_stb}, 32'd0);

        for (int c = 0; c < 2; c++)
            for (int s = 0; s < 2; s++)
                for (int r = 0; r < 2; r++)
                    scenario(c[0], s[0], r[0]);

        // R10: boot_done while running
        @(negedge clk); boot_done = 1'b1;
        for (int n = 0; n < 3; n++) begin
            @(negedge clk);
            chk("R10 strobe", {31'd0, fetch_stb}, 32'd0);
            chk("R10 core_rst", {31'd0, core_rst}, 32'd0);
        end
        boot_done = 1'b0;

        // R4: synchroniser latency from the running state
        ext_rst_n = 1'b0;
        for (int n = 1; n <= 3; n++) begin
            @(negedge clk);
            chk("R4 latency", {31'd0, core_rst}, {31'd0, n >= 3});
        end

        // R9: reset during lock wait, then warm release
        pwr_up = 1'b1; strap = 1'b1; bus_req = 1'b0;
        repeat (3) @(negedge clk);
        ext_rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk("R9 in lock", {31'd0, sp_clr}, 32'd1);
        pwr_up = 1'b0; ext_rst_n = 1'b0;
        repeat (4) @(negedge clk);
        ext_rst_n = 1'b1;
        for (int n = 1; n <= 4; n++) begin
            @(negedge clk);
            chk("R9 warm after lock", {31'd0, fetch_stb}, {31'd0, n == 3});
        end

        // R9: reset during boot phase
        strap = 1'b0; ext_rst_n = 1'b0;
        repeat (4) @(negedge clk);
        ext_rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R9 in boot", {31'd0, boot_req}, 32'd1);
        ext_rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 boot aborted", {31'd0, boot_req}, 32'd0);
        chk("R9 core_rst", {31'd0, core_rst}, 32'd1);
        chk_init("R9 init", 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end
endmodule